// File: doc/BRIEF.md
# Sequence-Armed Watchdog Timer

This block is a watchdog for a small 8-bit controller. It is disabled when reset ends. Software arms it by writing a two-byte key to one register address on the register bus. Once armed, a 14-bit counter advances on every machine-cycle strobe. If software does not rewrite the key before the counter wraps, the block drives an active-high reset pulse of fixed length. That pulse also returns the watchdog to its disarmed state.

Software cannot switch the watchdog off. Only the external reset or the watchdog's own pulse disarms it. Rewriting the same key while armed clears the counter, and this is how software services it. The counter does not advance while the core is powered down. After a power-down that ends through a level-sensitive wake interrupt, it stays frozen while that interrupt line is still low. A control bit decides whether the counter keeps running or freezes while the core is idle.

Top module: `seq_wdog`

## Requirements
- R1: The counter is 14 bits wide. It advances by one only on a clock edge where `mc_en_i` is high, the watchdog is armed and no pause applies. Starting from zero, the reset pulse follows the 16384th such advancing strobe and never an earlier one.
- R2: After `rst_ni` the watchdog is disarmed and `wdt_rst_o` is low. It arms only when byte 0x1E is written to address 0xA6 and then byte 0xE1 is written to address 0xA6.
- R3: No bus write disarms an armed watchdog. For example, writing 0x00 to address 0xA6 has no effect. Asserting `rst_ni` low disarms it and holds `wdt_rst_o` low.
- R4: When the counter wraps, `wdt_rst_o` goes high in the cycle that follows the clock edge of the wrapping strobe.
- R5: While `pdown_i` is high the counter holds its value.
- R6: The counter stays frozen in the following case. `wake_irq_ni` was low while `pdown_i` was high, and it has stayed low since then. Counting resumes on the first edge where `wake_irq_ni` is high.
- R7: Bit 0 of the byte written to address 0x8E sets the idle control bit, which is 0 after `rst_ni`. When the bit is 0, the counter advances during `idle_i`. When it is 1, the counter freezes during `idle_i` and continues from the same value afterwards.
- R8: Writing 0x1E and then 0xE1 to 0xA6 while the watchdog is armed clears the counter to zero. The next reset pulse then follows a full 16384 strobes after the write of 0xE1.
- R9: 0xE1 completes the key only if it is the next write to 0xA6 after 0xE1's partner 0x1E. Any other byte written to 0xA6 cancels the partial key. Writes to other addresses leave the partial key in place.
- R10: The reset pulse lasts PULSE_LEN cycles (default 96). The pulse clears the counter, the armed flag and the partial key, bus writes are ignored while it is high, and the watchdog stays disarmed afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low hardware reset |
| mc_en_i | input | 1 | Machine-cycle strobe, one clock wide per machine cycle |
| wr_en_i | input | 1 | Register-bus write strobe |
| wr_addr_i | input | 8 | Register-bus write address |
| wr_data_i | input | 8 | Register-bus write data |
| idle_i | input | 1 | Core is in idle mode |
| pdown_i | input | 1 | Core is in power-down mode |
| wake_irq_ni | input | 1 | Level-sensitive wake interrupt, active low |
| wdt_rst_o | output | 1 | Active-high watchdog reset pulse |

## Verification
A bus write takes effect at the clock edge that samples it. The counter then advances on each later qualifying edge. `wdt_rst_o` rises one register after the wrapping strobe: counting from the edge that accepts 0xE1, it is high after exactly 16384 advancing edges, or after the remaining count when part of the run was frozen. The pulse falls after another PULSE_LEN edges. The bench drives and samples on falling edges and counts edges from the accepting write. It checks that the output is still low one edge before the expected wrap, high on the expected edge, high on the last pulse cycle and low one edge later. Each disarm case is checked by watching the output stay low for longer than one full counter period.

// File: rtl/seq_wdog_pkg.sv
package seq_wdog_pkg;

  typedef enum logic {
    KEY_IDLE = 1'b0,
    KEY_HALF = 1'b1
  } key_state_e;

endpackage

// File: rtl/seq_wdog_unlock.sv
module seq_wdog_unlock
  import seq_wdog_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8,
  parameter logic [ADDR_W-1:0] KEY_ADDR   = 8'hA6,
  parameter logic [DATA_W-1:0] KEY_FIRST  = 8'h1E,
  parameter logic [DATA_W-1:0] KEY_SECOND = 8'hE1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              arm_o
);

  key_state_e st_q, st_d;
  logic       hit;

  always_comb begin
    hit   = wr_en_i && (wr_addr_i == KEY_ADDR);
    st_d  = st_q;
    arm_o = 1'b0;
    if (hit) begin
      if (wr_data_i == KEY_FIRST) begin
        st_d = KEY_HALF;
      end else begin
        st_d = KEY_IDLE;
        if (st_q == KEY_HALF && wr_data_i == KEY_SECOND) arm_o = 1'b1;
      end
    end
    // pulse wipes any partial key and blocks bus access
    if (clr_i) begin
      st_d  = KEY_IDLE;
      arm_o = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= KEY_IDLE;
    else         st_q <= st_d;
  end

endmodule

// File: rtl/seq_wdog_gate.sv
module seq_wdog_gate #(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h8E
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic              wr_bit_i,
  input  logic              en_i,
  input  logic              mc_en_i,
  input  logic              idle_i,
  input  logic              pdown_i,
  input  logic              wake_irq_ni,
  output logic              run_o,
  output logic              idle_frz_o,
  output logic              wake_hold_o
);

  logic frz_q, hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frz_q <= 1'b0;
    end else if (!clr_i && wr_en_i && wr_addr_i == CTRL_ADDR) begin
      frz_q <= wr_bit_i;
    end
  end

  // remembers a wake request seen in power-down until the line is released
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= 1'b0;
    end else if (wake_irq_ni) begin
      hold_q <= 1'b0;
    end else if (pdown_i) begin
      hold_q <= 1'b1;
    end
  end

  logic paused;
  always_comb begin
    paused = pdown_i
           | (hold_q & ~wake_irq_ni)
           | (idle_i & frz_q);
    run_o  = en_i & mc_en_i & ~paused;
  end

  assign idle_frz_o  = frz_q;
  assign wake_hold_o = hold_q;

endmodule

// File: rtl/seq_wdog_counter.sv
module seq_wdog_counter #(
  parameter int unsigned CNT_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             arm_i,
  input  logic             run_i,
  output logic             en_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             en_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      cnt_q <= '0;
    end else if (clr_i) begin
      en_q  <= 1'b0;
      cnt_q <= '0;
    end else if (arm_i) begin
      en_q  <= 1'b1;
      cnt_q <= '0;
    end else if (run_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // service write on the wrapping edge wins over the wrap
  assign ovf_o = run_i & ~arm_i & ~clr_i & (cnt_q == CNT_MAX);
  assign en_o  = en_q;
  assign cnt_o = cnt_q;

endmodule

// File: rtl/seq_wdog_pulse.sv
module seq_wdog_pulse #(
  parameter int unsigned PULSE_LEN = 96
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic pulse_o
);

  localparam int unsigned PC_W = $clog2(PULSE_LEN + 1);
  localparam logic [PC_W-1:0] PC_LOAD = PC_W'(PULSE_LEN - 1);

  logic            act_q;
  logic [PC_W-1:0] pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      pc_q  <= '0;
    end else if (act_q) begin
      if (pc_q == '0) act_q <= 1'b0;
      else            pc_q  <= pc_q - 1'b1;
    end else if (start_i) begin
      act_q <= 1'b1;
      pc_q  <= PC_LOAD;
    end
  end

  assign pulse_o = act_q;

endmodule

// File: rtl/seq_wdog.sv
module seq_wdog #(
  parameter int unsigned CNT_W      = 14,
  parameter int unsigned PULSE_LEN  = 96,
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned DATA_W     = 8,
  parameter logic [ADDR_W-1:0] KEY_ADDR   = 8'hA6,
  parameter logic [ADDR_W-1:0] CTRL_ADDR  = 8'h8E,
  parameter int unsigned       CTRL_BIT   = 0,
  parameter logic [DATA_W-1:0] KEY_FIRST  = 8'h1E,
  parameter logic [DATA_W-1:0] KEY_SECOND = 8'hE1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mc_en_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              idle_i,
  input  logic              pdown_i,
  input  logic              wake_irq_ni,
  output logic              wdt_rst_o
);

  logic             arm, run, en, ovf, pulse;
  logic             idle_frz, wake_hold;
  logic [CNT_W-1:0] cnt;

  seq_wdog_unlock #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .KEY_ADDR  (KEY_ADDR),
    .KEY_FIRST (KEY_FIRST),
    .KEY_SECOND(KEY_SECOND)
  ) i_unlock (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (pulse),
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .arm_o    (arm)
  );

  seq_wdog_gate #(
    .ADDR_W   (ADDR_W),
    .CTRL_ADDR(CTRL_ADDR)
  ) i_gate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (pulse),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_bit_i   (wr_data_i[CTRL_BIT]),
    .en_i       (en),
    .mc_en_i    (mc_en_i),
    .idle_i     (idle_i),
    .pdown_i    (pdown_i),
    .wake_irq_ni(wake_irq_ni),
    .run_o      (run),
    .idle_frz_o (idle_frz),
    .wake_hold_o(wake_hold)
  );

  seq_wdog_counter #(
    .CNT_W(CNT_W)
  ) i_counter (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (pulse),
    .arm_i (arm),
    .run_i (run),
    .en_o  (en),
    .cnt_o (cnt),
    .ovf_o (ovf)
  );

  seq_wdog_pulse #(
    .PULSE_LEN(PULSE_LEN)
  ) i_pulse (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(ovf),
    .pulse_o(pulse)
  );

  assign wdt_rst_o = pulse;

endmodule

// File: rtl/seq_wdog_chk.sv
module seq_wdog_chk #(
  parameter int unsigned CNT_W  = 14,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8,
  parameter logic [ADDR_W-1:0] KEY_ADDR   = 8'hA6,
  parameter logic [DATA_W-1:0] KEY_SECOND = 8'hE1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              idle_i,
  input logic              pdown_i,
  input logic              wake_irq_ni,
  input logic              wdt_rst_o,
  input logic              arm,
  input logic              en,
  input logic              ovf,
  input logic              idle_frz,
  input logic              wake_hold,
  input logic [CNT_W-1:0]  cnt
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  p_wrap_at_max_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wdt_rst_o) |-> $past(cnt) == CNT_MAX);

  p_arm_by_key_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(en) |-> $past(wr_en_i && wr_addr_i == KEY_ADDR && wr_data_i == KEY_SECOND));

  p_no_sw_disable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && !ovf && !wdt_rst_o) |=> en);

  p_pulse_after_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf |=> wdt_rst_o);

  p_pdown_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pdown_i && !arm && !ovf) |=> $stable(cnt));

  p_wake_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_hold && !wake_irq_ni && !arm && !ovf) |=> $stable(cnt));

  p_idle_freeze_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_i && idle_frz && !arm && !ovf) |=> $stable(cnt));

  p_service_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm |=> cnt == '0);

  p_pulse_state_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_rst_o |=> (!en && cnt == '0));

endmodule

bind seq_wdog seq_wdog_chk #(
  .CNT_W     (CNT_W),
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .KEY_ADDR  (KEY_ADDR),
  .KEY_SECOND(KEY_SECOND)
) i_seq_wdog_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .wr_addr_i  (wr_addr_i),
  .wr_data_i  (wr_data_i),
  .idle_i     (idle_i),
  .pdown_i    (pdown_i),
  .wake_irq_ni(wake_irq_ni),
  .wdt_rst_o  (wdt_rst_o),
  .arm        (arm),
  .en         (en),
  .ovf        (ovf),
  .idle_frz   (idle_frz),
  .wake_hold  (wake_hold),
  .cnt        (cnt)
);

// File: tb/test_seq_wdog.sv
module test_seq_wdog;

  localparam int FULL  = 16384;
  localparam int PLEN  = 96;
  localparam int QUIET = 16600;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       mc_en;
  logic       wr_en;
  logic [7:0] wr_addr;
  logic [7:0] wr_data;
  logic       idle;
  logic       pdown;
  logic       wake_n;
  logic       wdt_rst;

  int compared   = 0;
  int mismatched = 0;
  bit done       = 1'b0;

  always #4 clk = ~clk;

  seq_wdog i_seq_wdog (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .mc_en_i    (mc_en),
    .wr_en_i    (wr_en),
    .wr_addr_i  (wr_addr),
    .wr_data_i  (wr_data),
    .idle_i     (idle),
    .pdown_i    (pdown),
    .wake_irq_ni(wake_n),
    .wdt_rst_o  (wdt_rst)
  );

  task automatic chk_out(input logic exp, input string tag, input string what);
    compared++;
    if (wdt_rst !== exp) begin
      mismatched++;
      $display("FAIL %s %s: wdt_rst_o=%b expected %b", tag, what, wdt_rst, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic arm_key();
    bus_wr(8'hA6, 8'h1E);
    bus_wr(8'hA6, 8'hE1);
  endtask

  // n edges after the accepting edge: low at n-1, high at n, pulse PLEN long
  task automatic expect_wrap(input int n, input string tag);
    repeat (n - 1) @(negedge clk);
    chk_out(1'b0, tag, "one edge before wrap");
    @(negedge clk);
    chk_out(1'b1, tag, "on wrap edge");
    repeat (PLEN - 1) @(negedge clk);
    chk_out(1'b1, "R10", "last pulse cycle");
    @(negedge clk);
    chk_out(1'b0, "R10", "after pulse");
  endtask

  task automatic stay_quiet(input int n, input string tag);
    logic seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      seen |= wdt_rst;
    end
    compared++;
    if (seen !== 1'b0) begin
      mismatched++;
      $display("FAIL %s quiet window: wdt_rst_o seen=%b expected 0", tag, seen);
    end
  endtask

  task automatic t_reset();
    chk_out(1'b0, "R2", "during hardware reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_out(1'b0, "R2", "right after reset");
  endtask

  task automatic t_bad_keys();
    bus_wr(8'hA6, 8'h1E);
    bus_wr(8'hA6, 8'h55);
    bus_wr(8'hA6, 8'hE1);
    bus_wr(8'hA6, 8'hE1);
    bus_wr(8'h80, 8'h1E);
    bus_wr(8'hA6, 8'hE1);
    stay_quiet(QUIET, "R9");
  endtask

  task automatic t_arm_wrap();
    bus_wr(8'hA6, 8'h1E);
    bus_wr(8'h80, 8'hE1);  // other address leaves the partial key
    bus_wr(8'hA6, 8'hE1);
    expect_wrap(FULL, "R4");
    stay_quiet(QUIET, "R10");
  endtask

  task automatic t_service();
    arm_key();
    repeat (2000) @(negedge clk);
    arm_key();
    expect_wrap(FULL, "R8");
  endtask

  task automatic t_pdown();
    arm_key();
    repeat (1000) @(negedge clk);
    pdown = 1'b1;
    repeat (2000) @(negedge clk);
    pdown = 1'b0;
    expect_wrap(FULL - 1000, "R5");
  endtask

  task automatic t_wake();
    arm_key();
    repeat (1000) @(negedge clk);
    pdown = 1'b1; wake_n = 1'b0;
    repeat (1000) @(negedge clk);
    pdown = 1'b0;
    repeat (1000) @(negedge clk);
    wake_n = 1'b1;
    expect_wrap(FULL - 1000, "R6");
  endtask

  // strobe every other cycle, idle with control bit 0, junk write mid-run
  task automatic t_strobe_idle0();
    idle = 1'b1;
    arm_key();
    for (int i = 0; i < FULL - 1; i++) begin
      mc_en = 1'b0;
      if (i == 5000) begin
        wr_en = 1'b1; wr_addr = 8'hA6; wr_data = 8'h00;  // R3 no disable
      end
      @(negedge clk);
      wr_en = 1'b0;
      mc_en = 1'b1;
      @(negedge clk);
    end
    mc_en = 1'b0;
    @(negedge clk);
    chk_out(1'b0, "R1", "count at max without strobe");
    mc_en = 1'b1;
    @(negedge clk);
    chk_out(1'b1, "R7", "wrap while idle with bit clear");
    repeat (PLEN) @(negedge clk);
    chk_out(1'b0, "R10", "after pulse");
    idle = 1'b0;
  endtask

  task automatic t_idle1();
    bus_wr(8'h8E, 8'h01);
    arm_key();
    repeat (1000) @(negedge clk);
    idle = 1'b1;
    repeat (2000) @(negedge clk);
    idle = 1'b0;
    expect_wrap(FULL - 1000, "R7");
  endtask

  task automatic t_hw_reset();
    arm_key();
    repeat (1000) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk_out(1'b0, "R3", "output during hardware reset");
    rst_n = 1'b1;
    stay_quiet(QUIET, "R3");
  endtask

  initial begin
    rst_n = 1'b0; mc_en = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    idle = 1'b0; pdown = 1'b0; wake_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_bad_keys();
    t_arm_wrap();
    t_service();
    t_pdown();
    t_wake();
    t_strobe_idle0();
    t_idle1();
    t_hw_reset();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (198000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: run not finished, actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule